// File: doc/BRIEF.md
# Operand Register File with Forwarding

This block holds thirty-two 32-bit working registers for an arithmetic datapath and produces its operands. In every cycle it reads two registers onto the A and B operand buses and picks the multiplier's second operand. At the clock edge it accepts one pending result writeback. It also moves data through a 32-bit external exchange port. That port can load a register, load a register and keep a copy as an operand, or store a register to the outside one cycle later. Arithmetic and instruction sequencing happen outside the block. The pending writeback arrives on its own ports from a later stage.

Four forwarding paths hide the register write latency. Each has its own mode bit. Pending writeback data can replace the A operand or the B operand. It can also replace the value a store sends out. In addition, a load's incoming word can reach the A operand in the same cycle that it is written.

A small two-state machine runs the outgoing side of the exchange port. It has two states, IDLE and DRIVE:
- A store moves it to DRIVE. It does this from either state, so back-to-back stores keep it in DRIVE.
- Any other I/O code moves it to IDLE. This also happens from either state.
- In DRIVE the output enable is high and the latched store value is presented.

Top module: `fwd_regfile`

## Requirements
- R1: After reset, every register reads as zero, the captured operand is zero, the output word is zero and the output enable is low.
- R2: The A bus shows the register addressed by instruction bits 30:26. The B bus shows the register addressed by bits 25:21. Reads return the contents held before this cycle's edge.
- R3: When mode bit 0 is set, `cw_en_n` is low and the A address equals `cw_addr`, the A bus shows `cw_data` in the same cycle. Otherwise, including when the addresses differ, no such forwarding takes place.
- R4: When mode bit 11 is set, `cw_en_n` is low and the B address equals `cw_addr`, the B bus shows `cw_data` in the same cycle. Otherwise no such forwarding takes place.
- R5: I/O code 3 (instruction bits 14:13) writes `x_in` into the register addressed by bits 12:8 at the edge. If mode bit 3 is set and the A address equals that address, the A bus shows `x_in` in the same cycle. This takes priority over the R3 path.
- R6: I/O code 2 latches the register addressed by bits 12:8 at the edge. If mode bit 4 is set, `cw_en_n` is low and that address equals `cw_addr`, it latches `cw_data` instead. In the following cycle `x_oe` is high and `x_out` carries the latched word. Otherwise `x_oe` is low in that cycle.
- R7: I/O code 1 writes `x_in` into the register addressed by bits 12:8 and into the captured operand `x_cap` at the edge. No other code changes `x_cap`.
- R8: The multiplier's second operand `mul_b` is the B bus when instruction bit 2 is 0 and `x_cap` when it is 1.
- R9: When `cw_en_n` is low, `cw_data` is written into register `cw_addr` at the edge. If a load (code 1 or 3) targets the same register in the same cycle, the writeback value is the one kept.
- R10: I/O code 0 writes no register from `x_in`, leaves `x_cap` unchanged and leaves `x_oe` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr | input | 32 | Stage-1 instruction word (address, I/O and operand-select fields) |
| cw_en_n | input | 1 | Pending writeback enable, active low |
| cw_addr | input | 5 | Pending writeback register address |
| cw_data | input | DATA_W | Pending writeback data |
| mode | input | 16 | Forwarding enables: bit 0 C to A, bit 3 X to A, bit 4 C to store, bit 11 C to B |
| x_in | input | DATA_W | Incoming exchange word |
| a_bus | output | DATA_W | A operand |
| b_bus | output | DATA_W | B operand |
| mul_b | output | DATA_W | Multiplier second operand |
| x_cap | output | DATA_W | Captured incoming operand |
| x_out | output | DATA_W | Outgoing exchange word |
| x_oe | output | 1 | Outgoing word valid, high in the cycle after a store |

## Verification
Some behaviours are checked by the assertions on every cycle:
- the operand-select choice;
- each forwarding path whenever its enable, its pending write and its address match all coincide;
- the X-to-A path taking priority over the C-to-A path;
- the output enable and the forwarded store word in the cycle after a store;
- the captured operand loading only on I/O code 1 and otherwise holding.

Other behaviours only the bench's sweeps can show. These are the register contents seen over time, the writeback keeping its value over a load to the same register, and the absence of forwarding when a mode bit is clear or the addresses differ. These sweeps cover every register address against a reference array.

// File: rtl/fwd_regfile_pkg.sv
package fwd_regfile_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_AW  = 5;
    localparam int MODE_W  = 16;

    // instruction field positions
    localparam int A_LSB    = 26;
    localparam int B_LSB    = 21;
    localparam int D_LSB    = 8;
    localparam int IO_LSB   = 13;
    localparam int MSEL_BIT = 2;

    // mode bit positions
    localparam int MB_CA = 0;
    localparam int MB_XA = 3;
    localparam int MB_CX = 4;
    localparam int MB_CB = 11;

    typedef enum logic [1:0] {
        IO_NONE  = 2'd0,
        IO_LDCAP = 2'd1,
        IO_STORE = 2'd2,
        IO_LOAD  = 2'd3
    } io_op_e;

    typedef enum logic {
        XS_IDLE  = 1'b0,
        XS_DRIVE = 1'b1
    } xstate_e;

    function automatic logic [REG_AW-1:0] fld_a(input logic [INSTR_W-1:0] w);
        return w[A_LSB +: REG_AW];
    endfunction

    function automatic logic [REG_AW-1:0] fld_b(input logic [INSTR_W-1:0] w);
        return w[B_LSB +: REG_AW];
    endfunction

    function automatic logic [REG_AW-1:0] fld_d(input logic [INSTR_W-1:0] w);
        return w[D_LSB +: REG_AW];
    endfunction

    function automatic io_op_e fld_io(input logic [INSTR_W-1:0] w);
        return io_op_e'(w[IO_LSB +: 2]);
    endfunction

endpackage

// File: rtl/rf_store.sv
module rf_store #(
    parameter int DATA_W = 32,
    parameter int AW     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     ra,
    input  logic [AW-1:0]     rb,
    input  logic [AW-1:0]     rd,
    output logic [DATA_W-1:0] qa,
    output logic [DATA_W-1:0] qb,
    output logic [DATA_W-1:0] qd,
    input  logic              c_we,
    input  logic [AW-1:0]     c_addr,
    input  logic [DATA_W-1:0] c_data,
    input  logic              x_we,
    input  logic [AW-1:0]     x_addr,
    input  logic [DATA_W-1:0] x_data
);
    localparam int DEPTH = 1 << AW;

    logic [DATA_W-1:0] mem [DEPTH];

    // writeback is issued last so it wins a same-address collision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (x_we) mem[x_addr] <= x_data;
            if (c_we) mem[c_addr] <= c_data;
        end
    end

    assign qa = mem[ra];
    assign qb = mem[rb];
    assign qd = mem[rd];

endmodule

// File: rtl/rf_operand_mux.sv
module rf_operand_mux
    import fwd_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [MODE_W-1:0]  mode,
    input  logic               cw_en_n,
    input  logic [REG_AW-1:0]  cw_addr,
    input  logic [DATA_W-1:0]  cw_data,
    input  logic [DATA_W-1:0]  x_in,
    input  logic [DATA_W-1:0]  x_cap,
    input  logic [DATA_W-1:0]  qa,
    input  logic [DATA_W-1:0]  qb,
    input  logic [DATA_W-1:0]  qd,
    output logic [DATA_W-1:0]  a_bus,
    output logic [DATA_W-1:0]  b_bus,
    output logic [DATA_W-1:0]  mul_b,
    output logic [DATA_W-1:0]  st_val
);
    logic [REG_AW-1:0] a_adr, b_adr, d_adr;
    logic              c_pend;

    assign a_adr  = fld_a(instr);
    assign b_adr  = fld_b(instr);
    assign d_adr  = fld_d(instr);
    assign c_pend = !cw_en_n;

    always_comb begin
        a_bus = qa;
        if (mode[MB_CA] && c_pend && a_adr == cw_addr) a_bus = cw_data;
        if (fld_io(instr) == IO_LOAD && mode[MB_XA] && a_adr == d_adr) a_bus = x_in;
    end

    always_comb begin
        b_bus = qb;
        if (mode[MB_CB] && c_pend && b_adr == cw_addr) b_bus = cw_data;
    end

    always_comb begin
        st_val = qd;
        if (mode[MB_CX] && c_pend && d_adr == cw_addr) st_val = cw_data;
    end

    assign mul_b = instr[MSEL_BIT] ? x_cap : b_bus;

endmodule

// File: rtl/rf_xport.sv
module rf_xport
    import fwd_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  io_op_e            io,
    input  logic [DATA_W-1:0] x_in,
    input  logic [DATA_W-1:0] st_val,
    output logic [DATA_W-1:0] x_cap,
    output logic [DATA_W-1:0] x_out,
    output logic              x_oe
);
    xstate_e state, state_nx;

    always_comb begin
        unique case (state)
            XS_IDLE:  state_nx = (io == IO_STORE) ? XS_DRIVE : XS_IDLE;
            XS_DRIVE: state_nx = (io == IO_STORE) ? XS_DRIVE : XS_IDLE;
            default:  state_nx = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= XS_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_out <= '0;
            x_cap <= '0;
        end else begin
            if (io == IO_STORE) x_out <= st_val;
            if (io == IO_LDCAP) x_cap <= x_in;
        end
    end

    assign x_oe = (state == XS_DRIVE);

endmodule

// File: rtl/fwd_regfile.sv
module fwd_regfile
    import fwd_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] instr,
    input  logic               cw_en_n,
    input  logic [REG_AW-1:0]  cw_addr,
    input  logic [DATA_W-1:0]  cw_data,
    input  logic [MODE_W-1:0]  mode,
    input  logic [DATA_W-1:0]  x_in,
    output logic [DATA_W-1:0]  a_bus,
    output logic [DATA_W-1:0]  b_bus,
    output logic [DATA_W-1:0]  mul_b,
    output logic [DATA_W-1:0]  x_cap,
    output logic [DATA_W-1:0]  x_out,
    output logic               x_oe
);
    io_op_e            io;
    logic              x_we;
    logic [DATA_W-1:0] qa, qb, qd, st_val;
    logic              unused_bits;

    assign io   = fld_io(instr);
    assign x_we = (io == IO_LOAD) || (io == IO_LDCAP);

    assign unused_bits = ^{instr[31], instr[20:15], instr[7:3], instr[1:0],
                           mode[15:12], mode[10:5], mode[2:1]};

    rf_store #(.DATA_W(DATA_W), .AW(REG_AW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra     (fld_a(instr)),
        .rb     (fld_b(instr)),
        .rd     (fld_d(instr)),
        .qa     (qa),
        .qb     (qb),
        .qd     (qd),
        .c_we   (!cw_en_n),
        .c_addr (cw_addr),
        .c_data (cw_data),
        .x_we   (x_we),
        .x_addr (fld_d(instr)),
        .x_data (x_in)
    );

    rf_operand_mux #(.DATA_W(DATA_W)) u_mux (
        .instr   (instr),
        .mode    (mode),
        .cw_en_n (cw_en_n),
        .cw_addr (cw_addr),
        .cw_data (cw_data),
        .x_in    (x_in),
        .x_cap   (x_cap),
        .qa      (qa),
        .qb      (qb),
        .qd      (qd),
        .a_bus   (a_bus),
        .b_bus   (b_bus),
        .mul_b   (mul_b),
        .st_val  (st_val)
    );

    rf_xport #(.DATA_W(DATA_W)) u_xport (
        .clk    (clk),
        .rst_n  (rst_n),
        .io     (io),
        .x_in   (x_in),
        .st_val (st_val),
        .x_cap  (x_cap),
        .x_out  (x_out),
        .x_oe   (x_oe)
    );

endmodule

// File: rtl/fwd_regfile_chk.sv
module fwd_regfile_chk
    import fwd_regfile_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic [INSTR_W-1:0] instr,
    input logic               cw_en_n,
    input logic [REG_AW-1:0]  cw_addr,
    input logic [DATA_W-1:0]  cw_data,
    input logic [MODE_W-1:0]  mode,
    input logic [DATA_W-1:0]  x_in,
    input logic [DATA_W-1:0]  a_bus,
    input logic [DATA_W-1:0]  b_bus,
    input logic [DATA_W-1:0]  mul_b,
    input logic [DATA_W-1:0]  x_cap,
    input logic [DATA_W-1:0]  x_out,
    input logic               x_oe
);
    logic xa_hit, ca_hit, cb_hit, cx_hit;

    assign xa_hit = fld_io(instr) == IO_LOAD && mode[MB_XA] && fld_a(instr) == fld_d(instr);
    assign ca_hit = mode[MB_CA] && !cw_en_n && fld_a(instr) == cw_addr;
    assign cb_hit = mode[MB_CB] && !cw_en_n && fld_b(instr) == cw_addr;
    assign cx_hit = fld_io(instr) == IO_STORE && mode[MB_CX] && !cw_en_n && fld_d(instr) == cw_addr;

    // R3
    c_to_a_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ca_hit && !xa_hit) |-> a_bus == cw_data);

    // R4
    c_to_b_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cb_hit |-> b_bus == cw_data);

    // R5
    x_to_a_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xa_hit |-> a_bus == x_in);

    // R6
    store_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_io(instr) == IO_STORE |=> x_oe);

    // R6
    no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_io(instr) != IO_STORE |=> !x_oe);

    // R6
    store_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cx_hit |=> x_out == $past(cw_data));

    // R7
    capture_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_io(instr) == IO_LDCAP |=> x_cap == $past(x_in));

    // R7
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fld_io(instr) != IO_LDCAP |=> $stable(x_cap));

    // R8
    mul_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mul_b == (instr[MSEL_BIT] ? x_cap : b_bus));

endmodule

bind fwd_regfile fwd_regfile_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_fwd_regfile.sv
module sim_fwd_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        cw_en_n = 1'b1;
    logic [4:0]  cw_addr = '0;
    logic [31:0] cw_data = '0;
    logic [15:0] mode = '0;
    logic [31:0] x_in = '0;
    logic [31:0] a_bus, b_bus, mul_b, x_cap, x_out;
    logic        x_oe;

    int total = 0;
    int bad   = 0;

    logic [31:0] ref_rf [32];
    logic [31:0] ref_cap = '0;
    logic [31:0] ref_xo  = '0;

    always #2.5 clk = ~clk;

    fwd_regfile u0 (
        .clk(clk), .rst_n(rst_n), .instr(instr), .cw_en_n(cw_en_n),
        .cw_addr(cw_addr), .cw_data(cw_data), .mode(mode), .x_in(x_in),
        .a_bus(a_bus), .b_bus(b_bus), .mul_b(mul_b), .x_cap(x_cap),
        .x_out(x_out), .x_oe(x_oe)
    );

    function automatic logic [31:0] mk(input logic [4:0] a, input logic [4:0] b,
                                       input logic [4:0] d, input logic [1:0] io,
                                       input logic mb);
        return {1'b0, a, b, 5'd0, 1'b1, io, d, 5'd0, mb, 2'b00};
    endfunction

    function automatic logic [31:0] pat(input int i);
        return 32'h5A00_0000 + 32'(i) * 32'h0001_0307;
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic step(input string req, input logic [4:0] a, input logic [4:0] b,
                        input logic [4:0] d, input logic [1:0] io, input logic mb,
                        input logic cwn, input logic [4:0] cwa, input logic [31:0] cwd,
                        input logic [15:0] md, input logic [31:0] xi);
        logic [31:0] ea, eb;
        logic        eoe;
        @(negedge clk);
        instr = mk(a, b, d, io, mb); cw_en_n = cwn; cw_addr = cwa;
        cw_data = cwd; mode = md; x_in = xi;
        ea = ref_rf[a];
        if (md[0] && !cwn && a == cwa) ea = cwd;
        if (io == 2'd3 && md[3] && a == d) ea = xi;
        eb = ref_rf[b];
        if (md[11] && !cwn && b == cwa) eb = cwd;
        #1;
        chk(req, "a_bus", a_bus, ea);
        chk(req, "b_bus", b_bus, eb);
        chk(req, "mul_b", mul_b, mb ? ref_cap : eb);
        eoe = (io == 2'd2);
        if (eoe) ref_xo = (md[4] && !cwn && d == cwa) ? cwd : ref_rf[d];
        if (io == 2'd1) ref_cap = xi;
        if (io == 2'd1 || io == 2'd3) ref_rf[d] = xi;
        if (!cwn) ref_rf[cwa] = cwd;
        @(posedge clk);
        #1;
        chk(req, "x_oe", {31'd0, x_oe}, {31'd0, eoe});
        if (eoe) chk(req, "x_out", x_out, ref_xo);
        chk(req, "x_cap", x_cap, ref_cap);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) ref_rf[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1", "x_oe", {31'd0, x_oe}, 32'd0);
        chk("R1", "x_cap", x_cap, 32'd0);
        chk("R1", "x_out", x_out, 32'd0);
        for (int i = 0; i < 32; i++)
            step("R1", 5'(i), 5'(31 - i), 5'(i), 2'd0, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0, 32'hDEAD_0000);

        // R9 fill every register via writeback, no forwarding enabled
        for (int i = 0; i < 32; i++)
            step("R9", 5'(i), 5'(i), 5'(i), 2'd0, 1'b0, 1'b0, 5'(i), pat(i), 16'h0, 32'h0);

        // R2 plain reads
        for (int i = 0; i < 32; i++)
            step("R2", 5'(i), 5'(31 - i), 5'(i), 2'd0, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0, 32'h0);

        // R3 C to A: enabled/equal, disabled/equal, enabled/different
        for (int i = 0; i < 32; i++) begin
            step("R3", 5'(i), 5'(31 - i), 5'(i), 2'd0, 1'b0, 1'b0, 5'(i), ~pat(i), 16'h0001, 32'h0);
            step("R3", 5'(i), 5'(31 - i), 5'(i), 2'd0, 1'b0, 1'b0, 5'(i), pat(i) ^ 32'h0F0F, 16'h0000, 32'h0);
            step("R3", 5'(i ^ 1), 5'(i), 5'(i), 2'd0, 1'b0, 1'b0, 5'(i), pat(i) + 32'd9, 16'h0001, 32'h0);
        end

        // R4 C to B
        for (int i = 0; i < 32; i++) begin
            step("R4", 5'(31 - i), 5'(i), 5'(i), 2'd0, 1'b0, 1'b0, 5'(i), ~pat(i) + 32'd1, 16'h0800, 32'h0);
            step("R4", 5'(31 - i), 5'(i), 5'(i), 2'd0, 1'b0, 1'b0, 5'(i), pat(i) ^ 32'h00FF, 16'h0000, 32'h0);
            step("R4", 5'(i), 5'(i ^ 2), 5'(i), 2'd0, 1'b0, 1'b0, 5'(i), pat(i) + 32'd3, 16'h0800, 32'h0);
        end

        // R5 load and X to A forwarding
        for (int i = 0; i < 32; i++) begin
            step("R5", 5'(i), 5'(i), 5'(i), 2'd3, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0008, 32'hC000_0000 + 32'(i));
            step("R5", 5'(i), 5'(i), 5'(i), 2'd3, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0000, 32'hC100_0000 + 32'(i));
            step("R5", 5'(i ^ 4), 5'(i), 5'(i), 2'd3, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0008, 32'hC200_0000 + 32'(i));
        end
        // R5 priority over C to A; R9 writeback beats same-register load
        for (int i = 0; i < 32; i += 5) begin
            step("R5", 5'(i), 5'(i), 5'(i), 2'd3, 1'b0, 1'b0, 5'(i), 32'hB0B0_0000 + 32'(i), 16'h0009, 32'hE000_0000 + 32'(i));
            step("R9", 5'(i), 5'(i), 5'(i), 2'd0, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0000, 32'h0);
        end

        // R6 store: forwarded, disabled, different address; then idle
        for (int i = 0; i < 32; i++) begin
            step("R6", 5'(i), 5'(i), 5'(i), 2'd2, 1'b0, 1'b0, 5'(i), 32'hA000_0000 + 32'(i), 16'h0010, 32'h0);
            step("R6", 5'(i), 5'(i), 5'(i), 2'd2, 1'b0, 1'b0, 5'(i), 32'hA100_0000 + 32'(i), 16'h0000, 32'h0);
            step("R6", 5'(i), 5'(i), 5'(i), 2'd2, 1'b0, 1'b0, 5'(i ^ 8), 32'hA200_0000 + 32'(i), 16'h0010, 32'h0);
            step("R6", 5'(i), 5'(i), 5'(i), 2'd0, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0000, 32'h0);
        end

        // R7 capture, R8 operand select, R10 no-op I/O leaves state untouched
        for (int i = 0; i < 32; i++) begin
            step("R7", 5'(i), 5'(i ^ 3), 5'(i), 2'd1, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0000, 32'h7700_0000 + 32'(i));
            step("R8", 5'(i), 5'(i ^ 3), 5'(i), 2'd0, 1'b1, 1'b1, 5'd0, 32'd0, 16'h0000, 32'h0);
            step("R8", 5'(i), 5'(i ^ 3), 5'(i), 2'd0, 1'b0, 1'b1, 5'd0, 32'd0, 16'h0000, 32'h0);
            step("R10", 5'(i), 5'(i), 5'(i), 2'd0, 1'b1, 1'b1, 5'd0, 32'd0, 16'h0809, 32'h1234_5678);
            step("R10", 5'(i), 5'(i), 5'(i), 2'd0, 1'b1, 1'b1, 5'd0, 32'd0, 16'h0000, 32'h0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule